// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs exactly one NAND flash bus operation at a time for a host. The host writes a command byte or an address byte into a holding register, then writes a start code into the control register. The sequencer then generates the command-latch, address-latch, write-enable and read-enable strobes and drives or samples the flash data bus. A done flag clears when an operation is accepted and sets again when the operation has finished. The host polls this flag, so every accepted operation must end or be refused with an error flag.

Page data moves between the flash and an internal buffer RAM organised as 16-bit words. The host loads and reads this RAM through its own word port. A data-input operation sends the main area and then the spare area, from buffer byte 0 upward. A data-output operation writes the bytes it reads into the buffer, starting at word 0. A type field selects the transfer length of a data output: a full page, a device ID or a status byte. Configuration bits select an 8- or 16-bit flash bus, a 512- or 2048-byte page, interrupt suppression and big-endian byte packing.

Top module: `nand_seq`

## Requirements
- R1: Writing start code 1 (ctrl bits [2:0]) to the control register (regAddr 2) clears done on the next clock. The sequencer then emits one write cycle with CLE high, ALE low and dqOut[7:0] equal to the command register (regAddr 0), and then sets done.
- R2: Start code 2 emits one write cycle with ALE high, CLE low and dqOut[7:0] equal to the address register (regAddr 1), with done handled as in R1.
- R3: Start code 3 sends page+page/32 bytes from the buffer, byte 0 first, as WE# cycles with CLE and ALE low. The main area is followed by the spare area. WE# and RE# are never low together.
- R4: With config bit 0 set (16-bit bus), each bus cycle moves buffer word i as a whole halfword, and a page transfer takes half as many cycles.
- R5: On an 8-bit bus, buffer byte 2k is the low half of word k. When config bit 3 (big-endian) is set, byte 2k is the high half of word k instead.
- R6: Start code 4 reads the flash with RE# strobes while the bus is not driven (dqOe low). Ctrl bits [5:4] select the length: 0 gives a page (page+page/32 bytes), 1 gives 4 ID bytes, 2 or 3 gives one status cycle. The data is stored from buffer word 0 upward.
- R7: After the last read cycle of a data output, done stays low until rdyBusy is high. While done is high, all strobes are inactive.
- R8: A start code written while an operation runs is ignored. The running transfer continues unchanged and the sticky errBusy output sets.
- R9: Config bit 1 selects a 2048-byte page. If the buffer cannot hold that page plus its spare area, a data input or a page data output is refused: errCfg sets, done stays high and no strobe toggles.
- R10: After reset, and on the clock after a control write with bit 7 set, the sequencer is idle. Done is high, both error flags are clear and all strobes are inactive.
- R11: Each WE# or RE# low pulse lasts exactly T_LOW clocks. Consecutive pulses within one operation are separated by at least T_HIGH clocks high.
- R12: When an operation completes and config bit 2 (interrupt disable) is clear, irq pulses high for one clock. When bit 2 is set, irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Host register write strobe |
| regAddr | input | 2 | 0 command, 1 address, 2 control, 3 config |
| regWrData | input | 8 | Host register write data |
| bufWrEn | input | 1 | Host buffer word write |
| bufAddr | input | $clog2(BUF_BYTES/2) | Host buffer word index |
| bufWrData | input | 16 | Host buffer write word |
| bufRdData | output | 16 | Host buffer read word, one clock after bufAddr |
| done | output | 1 | Operation complete flag |
| irq | output | 1 | One-clock completion pulse |
| errBusy | output | 1 | Sticky: start code arrived while busy |
| errCfg | output | 1 | Sticky: page size does not fit the buffer |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write enable, active low |
| reN | output | 1 | Read enable, active low |
| dqOut | output | 16 | Flash data bus output |
| dqOe | output | 1 | Flash data bus output enable |
| dqIn | input | 16 | Flash data bus input |
| rdyBusy | input | 1 | Flash ready (high) / busy (low) |

## Verification
A corrupted cycle counter or a stuck phase shows up at the pins as a wrong number of WE# or RE# pulses, or as done never returning. Both are visible within one operation. A pointer or lane-select error appears as shifted or byte-swapped data: on dqOut at the first affected write cycle, or in the host buffer read-back right after a data output. A wrong phase count changes the strobe pulse width within a single bus cycle. A broken busy or config guard shows as an error flag or a stray strobe within the same clock as the start write.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_DIN  = 2'd2,
    OP_DOUT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_WAIT = 2'd3
  } phase_e;

  localparam logic [2:0] START_CMD  = 3'd1;
  localparam logic [2:0] START_ADDR = 3'd2;
  localparam logic [2:0] START_DIN  = 3'd3;
  localparam logic [2:0] START_DOUT = 3'd4;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_CFG  = 2'd3;

  typedef struct packed {
    logic cle;
    logic ale;
    logic weLow;
    logic reLow;
    logic busOe;
    op_e  op;
    logic ptrClear;
    logic ptrStep;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
`timescale 1ns/1ps
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int BUF_BYTES  = 1024,
  parameter int SMALL_PAGE = 512,
  parameter int LARGE_PAGE = 2048,
  parameter int SPARE_DIV  = 32,
  parameter int ID_BYTES   = 4,
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWr,
  input  logic [2:0] ctlCode,
  input  logic [1:0] ctlType,
  input  logic       ctlRst,
  input  logic       cfgWide,
  input  logic       cfgBigPage,
  input  logic       cfgIntDis,
  input  logic       rdyBusy,
  output strobe_t    stb,
  output logic       done,
  output logic       irq,
  output logic       errBusy,
  output logic       errCfg
);

  localparam int SMALL_TOTAL = SMALL_PAGE + SMALL_PAGE / SPARE_DIV;
  localparam int LARGE_TOTAL = LARGE_PAGE + LARGE_PAGE / SPARE_DIV;
  localparam bit LARGE_OK    = (LARGE_TOTAL <= BUF_BYTES);
  localparam int CYC_W       = $clog2(LARGE_TOTAL + 1);
  localparam int PH_MAX      = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int PH_W        = $clog2(PH_MAX + 1);

  phase_e            phase;
  op_e               op;
  logic [PH_W-1:0]   phCnt;
  logic [CYC_W-1:0]  cycLeft;

  logic              softRst;
  logic              startReq;
  op_e               reqOp;
  logic [CYC_W-1:0]  reqLen;
  logic [CYC_W-1:0]  pageTotal;
  logic              pageKind;
  logic              cfgReject;
  logic              lowEnd;
  logic              highEnd;

  assign softRst  = ctlWr && ctlRst;
  assign startReq = ctlWr && !ctlRst &&
                    (ctlCode == START_CMD || ctlCode == START_ADDR ||
                     ctlCode == START_DIN || ctlCode == START_DOUT);
  assign lowEnd   = (phase == PH_LOW)  && (phCnt == PH_W'(T_LOW - 1));
  assign highEnd  = (phase == PH_HIGH) && (phCnt == PH_W'(T_HIGH - 1));

  // Decode of the requested operation and its length in bus cycles
  always_comb begin
    pageTotal = cfgBigPage ? CYC_W'(LARGE_TOTAL) : CYC_W'(SMALL_TOTAL);
    reqOp     = OP_CMD;
    reqLen    = CYC_W'(1);
    pageKind  = 1'b0;
    case (ctlCode)
      START_ADDR: reqOp = OP_ADDR;
      START_DIN: begin
        reqOp    = OP_DIN;
        pageKind = 1'b1;
        reqLen   = cfgWide ? (pageTotal >> 1) : pageTotal;
      end
      START_DOUT: begin
        reqOp = OP_DOUT;
        if (ctlType[1]) begin
          reqLen = CYC_W'(1);
        end else if (ctlType[0]) begin
          reqLen = cfgWide ? CYC_W'(ID_BYTES / 2) : CYC_W'(ID_BYTES);
        end else begin
          pageKind = 1'b1;
          reqLen   = cfgWide ? (pageTotal >> 1) : pageTotal;
        end
      end
      default: reqOp = OP_CMD;
    endcase
    cfgReject = pageKind && cfgBigPage && !LARGE_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      op      <= OP_CMD;
      phCnt   <= '0;
      cycLeft <= '0;
      done    <= 1'b1;
      irq     <= 1'b0;
      errBusy <= 1'b0;
      errCfg  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (softRst) begin
        phase   <= PH_IDLE;
        phCnt   <= '0;
        done    <= 1'b1;
        errBusy <= 1'b0;
        errCfg  <= 1'b0;
      end else begin
        if (startReq && phase != PH_IDLE) errBusy <= 1'b1;
        case (phase)
          PH_IDLE: begin
            if (startReq) begin
              if (cfgReject) begin
                errCfg <= 1'b1;
              end else begin
                op      <= reqOp;
                cycLeft <= reqLen;
                phCnt   <= '0;
                done    <= 1'b0;
                phase   <= PH_LOW;
              end
            end
          end
          PH_LOW: begin
            if (lowEnd) begin
              phCnt <= '0;
              phase <= PH_HIGH;
            end else begin
              phCnt <= phCnt + PH_W'(1);
            end
          end
          PH_HIGH: begin
            if (highEnd) begin
              phCnt <= '0;
              if (cycLeft == CYC_W'(1)) begin
                if (op == OP_DOUT) begin
                  phase <= PH_WAIT;
                end else begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
                  irq   <= !cfgIntDis;
                end
              end else begin
                cycLeft <= cycLeft - CYC_W'(1);
                phase   <= PH_LOW;
              end
            end else begin
              phCnt <= phCnt + PH_W'(1);
            end
          end
          PH_WAIT: begin
            if (rdyBusy) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
              irq   <= !cfgIntDis;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // Strobe bundle to the datapath
  always_comb begin
    logic active;
    active       = (phase == PH_LOW) || (phase == PH_HIGH);
    stb.cle      = active && (op == OP_CMD);
    stb.ale      = active && (op == OP_ADDR);
    stb.weLow    = (phase == PH_LOW) && (op != OP_DOUT);
    stb.reLow    = (phase == PH_LOW) && (op == OP_DOUT);
    stb.busOe    = active && (op != OP_DOUT);
    stb.op       = op;
    stb.ptrClear = (phase == PH_IDLE) && startReq && !cfgReject && !softRst;
    stb.ptrStep  = highEnd && !softRst;
    stb.capture  = lowEnd && (op == OP_DOUT) && !softRst;
  end

endmodule

// File: rtl/nand_seq_dp.sv
`timescale 1ns/1ps
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int BUF_BYTES = 1024
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWr,
  input  logic [1:0]                       regAddr,
  input  logic [7:0]                       regWrData,
  input  logic                             bufWrEn,
  input  logic [$clog2(BUF_BYTES/2)-1:0]   bufAddr,
  input  logic [15:0]                      bufWrData,
  output logic [15:0]                      bufRdData,
  input  strobe_t                          stb,
  input  logic [15:0]                      dqIn,
  output logic                             cle,
  output logic                             ale,
  output logic                             weN,
  output logic                             reN,
  output logic [15:0]                      dqOut,
  output logic                             dqOe,
  output logic                             cfgWide,
  output logic                             cfgBigPage,
  output logic                             cfgIntDis
);

  localparam int BUF_WORDS = BUF_BYTES / 2;
  localparam int AW        = $clog2(BUF_WORDS);
  localparam int PTR_W     = AW + 1;

  logic [7:0]       cmdReg;
  logic [7:0]       addrReg;
  logic [3:0]       cfgReg;
  logic [PTR_W-1:0] bytePtr;
  logic [15:0]      mem [BUF_WORDS];

  logic             cfgBigEnd;
  logic [AW-1:0]    wordIdx;
  logic             hiLane;
  logic [15:0]      engWord;
  logic [7:0]       engByte;
  logic [1:0]       engBe;
  logic [15:0]      engWrData;

  assign cfgWide    = cfgReg[0];
  assign cfgBigPage = cfgReg[1];
  assign cfgIntDis  = cfgReg[2];
  assign cfgBigEnd  = cfgReg[3];

  assign wordIdx = bytePtr[PTR_W-1:1];
  assign hiLane  = bytePtr[0] ^ cfgBigEnd;
  assign engWord = mem[wordIdx];
  assign engByte = hiLane ? engWord[15:8] : engWord[7:0];

  // Host register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      cfgReg  <= '0;
    end else if (regWr) begin
      case (regAddr)
        REG_CMD:  cmdReg  <= regWrData;
        REG_ADDR: addrReg <= regWrData;
        REG_CFG:  cfgReg  <= regWrData[3:0];
        default:  ;
      endcase
    end
  end

  // Buffer byte pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePtr <= '0;
    end else if (stb.ptrClear) begin
      bytePtr <= '0;
    end else if (stb.ptrStep) begin
      bytePtr <= bytePtr + (cfgWide ? PTR_W'(2) : PTR_W'(1));
    end
  end

  // Lane enables and data for captured read data
  always_comb begin
    if (cfgWide) begin
      engBe     = 2'b11;
      engWrData = dqIn;
    end else begin
      engBe     = hiLane ? 2'b10 : 2'b01;
      engWrData = {dqIn[7:0], dqIn[7:0]};
    end
  end

  // Buffer RAM: engine writes take priority over host writes
  always_ff @(posedge clk) begin
    if (stb.capture) begin
      if (engBe[0]) mem[wordIdx][7:0]  <= engWrData[7:0];
      if (engBe[1]) mem[wordIdx][15:8] <= engWrData[15:8];
    end else if (bufWrEn) begin
      mem[bufAddr] <= bufWrData;
    end
    bufRdData <= mem[bufAddr];
  end

  // Flash pins
  always_comb begin
    cle  = stb.cle;
    ale  = stb.ale;
    weN  = !stb.weLow;
    reN  = !stb.reLow;
    dqOe = stb.busOe;
    case (stb.op)
      OP_CMD:  dqOut = {8'h00, cmdReg};
      OP_ADDR: dqOut = {8'h00, addrReg};
      OP_DIN:  dqOut = cfgWide ? engWord : {8'h00, engByte};
      default: dqOut = 16'h0000;
    endcase
  end

endmodule

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int BUF_BYTES  = 1024,
  parameter int SMALL_PAGE = 512,
  parameter int LARGE_PAGE = 2048,
  parameter int SPARE_DIV  = 32,
  parameter int ID_BYTES   = 4,
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWr,
  input  logic [1:0]                     regAddr,
  input  logic [7:0]                     regWrData,
  input  logic                           bufWrEn,
  input  logic [$clog2(BUF_BYTES/2)-1:0] bufAddr,
  input  logic [15:0]                    bufWrData,
  output logic [15:0]                    bufRdData,
  output logic                           done,
  output logic                           irq,
  output logic                           errBusy,
  output logic                           errCfg,
  output logic                           cle,
  output logic                           ale,
  output logic                           weN,
  output logic                           reN,
  output logic [15:0]                    dqOut,
  output logic                           dqOe,
  input  logic [15:0]                    dqIn,
  input  logic                           rdyBusy
);

  strobe_t stb;
  logic    ctlWr;
  logic    cfgWide;
  logic    cfgBigPage;
  logic    cfgIntDis;

  assign ctlWr = regWr && (regAddr == REG_CTRL);

  nand_seq_ctrl #(
    .BUF_BYTES (BUF_BYTES),
    .SMALL_PAGE(SMALL_PAGE),
    .LARGE_PAGE(LARGE_PAGE),
    .SPARE_DIV (SPARE_DIV),
    .ID_BYTES  (ID_BYTES),
    .T_LOW     (T_LOW),
    .T_HIGH    (T_HIGH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWr     (ctlWr),
    .ctlCode   (regWrData[2:0]),
    .ctlType   (regWrData[5:4]),
    .ctlRst    (regWrData[7]),
    .cfgWide   (cfgWide),
    .cfgBigPage(cfgBigPage),
    .cfgIntDis (cfgIntDis),
    .rdyBusy   (rdyBusy),
    .stb       (stb),
    .done      (done),
    .irq       (irq),
    .errBusy   (errBusy),
    .errCfg    (errCfg)
  );

  nand_seq_dp #(
    .BUF_BYTES(BUF_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .bufWrEn   (bufWrEn),
    .bufAddr   (bufAddr),
    .bufWrData (bufWrData),
    .bufRdData (bufRdData),
    .stb       (stb),
    .dqIn      (dqIn),
    .cle       (cle),
    .ale       (ale),
    .weN       (weN),
    .reN       (reN),
    .dqOut     (dqOut),
    .dqOe      (dqOe),
    .cfgWide   (cfgWide),
    .cfgBigPage(cfgBigPage),
    .cfgIntDis (cfgIntDis)
  );

endmodule

// File: rtl/nand_seq_chk.sv
`timescale 1ns/1ps
module nand_seq_chk #(
  parameter int T_LOW = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic       done,
  input logic       irq,
  input logic       errBusy,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       dqOe
);

  logic       softRst;
  logic       softRstD;
  logic [7:0] weLowCnt;

  assign softRst = regWr && (regAddr == 2'd2) && regWrData[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRstD <= 1'b0;
      weLowCnt <= '0;
    end else begin
      softRstD <= softRst;
      weLowCnt <= weN ? 8'd0 : (weLowCnt + 8'd1);
    end
  end

  // R1: command and address latches never together
  a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  // R3: no simultaneous read and write strobe
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  // R6: bus released while reading
  a_r6_read_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !dqOe);

  // R7: strobes idle whenever done is high
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (weN && reN && !cle && !ale));

  // R8: busy error holds until a soft reset
  a_r8_busy_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errBusy && !softRst) |=> errBusy);

  // R11: write-enable low pulse width
  a_r11_we_low_width: assert property (@(posedge clk) disable iff (!rstN || softRstD)
    (weN && $past(!weN)) |-> (weLowCnt == 8'(T_LOW)));

  // R12: interrupt pulse only with done
  a_r12_irq_on_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done);

endmodule

bind nand_seq nand_seq_chk #(.T_LOW(T_LOW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .done     (done),
  .irq      (irq),
  .errBusy  (errBusy),
  .cle      (cle),
  .ale      (ale),
  .weN      (weN),
  .reN      (reN),
  .dqOe     (dqOe)
);

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb;

  localparam int BUF_BYTES = 1024;
  localparam int T_LOW     = 3;
  localparam int T_HIGH    = 2;
  localparam int AW        = $clog2(BUF_BYTES/2);
  localparam int PAGE_TOT  = 512 + 512/32;
  localparam int MON_MAX   = 2200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [7:0]    regWrData = '0;
  logic          bufWrEn = 1'b0;
  logic [AW-1:0] bufAddr = '0;
  logic [15:0]   bufWrData = '0;
  logic [15:0]   bufRdData;
  logic          done, irq, errBusy, errCfg, cle, ale, weN, reN, dqOe;
  logic [15:0]   dqOut;
  logic [15:0]   dqIn = '0;
  logic          rdyBusy = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nand_seq #(.BUF_BYTES(BUF_BYTES), .T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .bufWrEn(bufWrEn), .bufAddr(bufAddr), .bufWrData(bufWrData), .bufRdData(bufRdData),
    .done(done), .irq(irq), .errBusy(errBusy), .errCfg(errCfg),
    .cle(cle), .ale(ale), .weN(weN), .reN(reN), .dqOut(dqOut), .dqOe(dqOe),
    .dqIn(dqIn), .rdyBusy(rdyBusy));

  // ---------------- pin monitors ----------------
  logic        monEn = 1'b0;
  logic [15:0] wrVal [MON_MAX];
  logic        wrCle [MON_MAX];
  logic        wrAle [MON_MAX];
  int          wrCount = 0;
  int          rdCount = 0;
  int          irqCount = 0;
  bit          oeBad = 1'b0;
  realtime     tFall = 0, tRise = 0, lastLow = 0, minGap = 1.0e9;
  bit          haveRise = 1'b0;

  always @(negedge weN) if (monEn) begin
    if (haveRise && ($realtime - tRise) < minGap) minGap = $realtime - tRise;
    tFall = $realtime;
  end

  always @(posedge weN) if (monEn) begin
    lastLow = $realtime - tFall;
    tRise = $realtime;
    haveRise = 1'b1;
    if (wrCount < MON_MAX) begin
      wrVal[wrCount] = dqOut;
      wrCle[wrCount] = cle;
      wrAle[wrCount] = ale;
    end
    wrCount++;
  end

  always @(negedge reN) if (monEn) dqIn = pat(rdCount);
  always @(posedge reN) if (monEn) rdCount++;
  always @(negedge clk) if (monEn) begin
    if (irq) irqCount++;
    if (!reN && dqOe) oeBad = 1'b1;
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] pat(input int i);
    return 16'((i * 40503 + 17) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] byteOf(input logic [15:0] w, input bit hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    wrCount = 0; rdCount = 0; irqCount = 0; oeBad = 1'b0;
    haveRise = 1'b0; minGap = 1.0e9;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic bufWrite(input int a, input logic [15:0] d);
    @(negedge clk);
    bufWrEn = 1'b1; bufAddr = AW'(a); bufWrData = d;
    @(negedge clk);
    bufWrEn = 1'b0;
  endtask

  task automatic bufRead(input int a, output logic [15:0] d);
    @(negedge clk);
    bufAddr = AW'(a);
    @(negedge clk);
    d = bufRdData;
  endtask

  task automatic waitDone(input int limit);
    int n;
    n = 0;
    while (!done && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  logic [15:0] bufCopy [BUF_BYTES/2];

  task automatic fillBuffer();
    for (int k = 0; k < PAGE_TOT/2; k++) begin
      bufCopy[k] = 16'($urandom);
      bufWrite(k, bufCopy[k]);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int          bad;
    int          badIdx;
    logic [15:0] badAct, badExp;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(done && !errBusy && !errCfg && weN && reN && !cle && !ale,
          "R10 reset state", {done, errBusy, errCfg, weN, reN, cle, ale}, 7'b1001100);
    monEn = 1'b1;

    // R1 + R12 + R11: command cycle
    for (int r = 0; r < 3; r++) begin
      b = 8'($urandom);
      regWrite(2'd0, b);
      regWrite(2'd3, 8'h00);
      clearMon();
      regWrite(2'd2, 8'h01);
      check(!done, "R1 done cleared after start", done, 0);
      waitDone(200);
      check(done && wrCount == 1 && wrCle[0] && !wrAle[0] && wrVal[0][7:0] == b,
            "R1 command cycle", {wrCount[7:0], wrCle[0], wrAle[0], wrVal[0][7:0]},
            {8'd1, 2'b10, b});
      check(lastLow == T_LOW * 10.0, "R11 low width", 32'(int'(lastLow)), T_LOW * 10);
      @(negedge clk);
      check(irqCount == 1, "R12 irq pulse", irqCount, 1);
    end

    // R12: interrupt suppressed
    regWrite(2'd3, 8'h04);
    clearMon();
    regWrite(2'd2, 8'h01);
    waitDone(200);
    repeat (2) @(negedge clk);
    check(irqCount == 0, "R12 irq disabled", irqCount, 0);

    // R2: address cycle
    b = 8'($urandom);
    regWrite(2'd1, b);
    regWrite(2'd3, 8'h00);
    clearMon();
    regWrite(2'd2, 8'h02);
    check(!done, "R2 done cleared after start", done, 0);
    waitDone(200);
    check(done && wrCount == 1 && !wrCle[0] && wrAle[0] && wrVal[0][7:0] == b,
          "R2 address cycle", {wrCount[7:0], wrCle[0], wrAle[0], wrVal[0][7:0]},
          {8'd1, 2'b01, b});

    // R3 + R5: data-in 8-bit, little then big endian
    for (int be = 0; be < 2; be++) begin
      fillBuffer();
      regWrite(2'd3, be ? 8'h08 : 8'h00);
      clearMon();
      regWrite(2'd2, 8'h03);
      waitDone(20000);
      bad = 0; badIdx = 0; badAct = 0; badExp = 0;
      for (int j = PAGE_TOT - 1; j >= 0; j--) begin
        logic [7:0] e;
        e = byteOf(bufCopy[j >> 1], 1'(j) ^ 1'(be));
        if (wrVal[j][7:0] != e || wrCle[j] || wrAle[j]) begin
          bad++; badIdx = j; badAct = wrVal[j]; badExp = {8'h00, e};
        end
      end
      check(wrCount == PAGE_TOT, be ? "R3 beat count (BE)" : "R3 beat count",
            wrCount, PAGE_TOT);
      check(bad == 0, be ? "R5 big-endian byte order" : "R5 little-endian byte order",
            {badIdx[15:0], badAct}, {badIdx[15:0], badExp});
      check(minGap >= T_HIGH * 10.0, "R11 high gap", 32'(int'(minGap)), T_HIGH * 10);
    end

    // R4: data-in 16-bit
    fillBuffer();
    regWrite(2'd3, 8'h01);
    clearMon();
    regWrite(2'd2, 8'h03);
    waitDone(20000);
    bad = 0; badAct = 0; badExp = 0;
    for (int k = 0; k < PAGE_TOT/2; k++)
      if (wrVal[k] != bufCopy[k]) begin
        bad++; badAct = wrVal[k]; badExp = bufCopy[k];
      end
    check(wrCount == PAGE_TOT/2 && bad == 0, "R4 wide data-in",
          {wrCount[15:0], badAct}, {16'(PAGE_TOT/2), badExp});

    // R6: page data-out 8-bit little endian
    regWrite(2'd3, 8'h00);
    clearMon();
    regWrite(2'd2, 8'h04);
    waitDone(20000);
    check(rdCount == PAGE_TOT && wrCount == 0 && !oeBad, "R6 page read beats",
          {rdCount[15:0], wrCount[7:0], 7'd0, oeBad}, {16'(PAGE_TOT), 16'd0});
    bad = 0; badAct = 0; badExp = 0;
    for (int k = 0; k < PAGE_TOT/2; k++) begin
      logic [15:0] e;
      e = {pat(2*k+1)[7:0], pat(2*k)[7:0]};
      bufRead(k, w);
      if (w != e) begin
        bad++; badAct = w; badExp = e;
      end
    end
    check(bad == 0, "R6 page read buffer", badAct, badExp);

    // R4 + R6: ID read on 16-bit bus lands as halfwords
    regWrite(2'd3, 8'h01);
    clearMon();
    regWrite(2'd2, 8'h14);
    waitDone(500);
    check(rdCount == 2, "R6 ID read wide beats", rdCount, 2);
    bufRead(1, w);
    check(w == pat(1), "R4 ID halfword stored", w, pat(1));

    // R6: ID read 8-bit
    regWrite(2'd3, 8'h00);
    clearMon();
    regWrite(2'd2, 8'h14);
    waitDone(500);
    check(rdCount == 4, "R6 ID read beats", rdCount, 4);
    bufRead(1, w);
    check(w == {pat(3)[7:0], pat(2)[7:0]}, "R6 ID bytes", w, {pat(3)[7:0], pat(2)[7:0]});

    // R6 + R7: status read waits for ready
    rdyBusy = 1'b0;
    clearMon();
    regWrite(2'd2, 8'h24);
    repeat (40) @(negedge clk);
    check(!done && rdCount == 1, "R7 done held while busy", {done, rdCount[7:0]}, 9'h001);
    rdyBusy = 1'b1;
    waitDone(10);
    check(done, "R7 done after ready", done, 1);
    bufRead(0, w);
    check(w[7:0] == pat(0)[7:0], "R6 status byte", w[7:0], pat(0)[7:0]);

    // R8: start while busy is ignored
    fillBuffer();
    clearMon();
    regWrite(2'd2, 8'h03);
    repeat (50) @(negedge clk);
    regWrite(2'd2, 8'h01);
    check(errBusy, "R8 busy error set", errBusy, 1);
    waitDone(20000);
    bad = 0;
    for (int j = 0; j < PAGE_TOT; j++) if (wrCle[j]) bad++;
    check(wrCount == PAGE_TOT && bad == 0, "R8 transfer unaffected",
          {wrCount[15:0], bad[15:0]}, {16'(PAGE_TOT), 16'd0});
    check(errBusy, "R8 busy error sticky", errBusy, 1);

    // R10: soft reset mid transfer
    regWrite(2'd2, 8'h04);
    repeat (40) @(negedge clk);
    regWrite(2'd2, 8'h80);
    check(done && reN && weN && !errBusy && !errCfg, "R10 soft reset",
          {done, reN, weN, errBusy, errCfg}, 5'b11100);

    // R9: large page refused with 1 KB buffer
    clearMon();
    regWrite(2'd3, 8'h02);
    regWrite(2'd2, 8'h03);
    repeat (20) @(negedge clk);
    check(errCfg && done && wrCount == 0, "R9 large page data-in refused",
          {errCfg, done, wrCount[7:0]}, 10'h300);
    regWrite(2'd2, 8'h04);
    repeat (20) @(negedge clk);
    check(done && rdCount == 0, "R9 large page read refused", {done, rdCount[7:0]}, 9'h100);

    finishRun();
  end

endmodule